// File: doc/BRIEF.md
# Sequence-Keyed Watchdog Timer

This block is a watchdog counter behind a small memory-mapped register interface. Software sets a reload value, chooses a count rate, and then arms the counter. The counter can only be started or stopped by writing a two-word key sequence to a dedicated key register. The counter counts up from the reload value on a 32768 Hz tick, which can be divided by a power of two. When the counter passes its all-ones value, the block raises a reset-request pulse and reloads. Software keeps the counter from expiring by writing a new value to a trigger register. Each such write reloads the counter.

The key register reads back whatever was last written to it. It does not show whether the counter is running, and no other bit does either. Software that needs to know whether the counter is running samples the count register twice and compares the two values. The register interface is a plain single-cycle write strobe with address and data, plus a combinational read-data path. It has no valid/ready handshake, so back-pressure never applies. A write completes on the clock edge where `wr_en_i` is high.

Word addresses: 0 = control, 1 = count (read-only), 2 = load, 3 = trigger, 4 = key.

Top module: `seqwd_top`

## Requirements
- R1: After reset the counter is stopped and reads 0. The control register reads 0, the key register reads 0x0000, and `rst_req_o` is low.
- R2: The counter starts at the edge of a key write whose low 16 bits are 0x4444, when the previous key write was 0xBBBB.
- R3: The counter stops at the edge of a key write whose low 16 bits are 0x5555, when the previous key write was 0xAAAA.
- R4: Any key write that is not the expected second word clears the pending sequence. A 0x4444 write without a 0xBBBB key write directly before it leaves a stopped counter stopped. Writes to other registers between the two key words do not break the sequence.
- R5: The key register (address 4) reads back the low 16 bits of the last value written, zero-extended, whatever the running state.
- R6: With the prescaler disabled (control bit 5 = 0), a running counter advances by 1 on every cycle where `tick_i` is high.
- R7: With the prescaler enabled (control bit 5 = 1) and control bits 4:2 = p, a running counter advances once every 2^p ticks. The divider restarts at each start.
- R8: Writes to the control register are ignored while the counter is running. Only bits 5:2 are stored, and the other bits read as 0.
- R9: When a running counter at 0xFFFFFFFF advances, it reloads from the load register, and `rst_req_o` is high for the following cycle only.
- R10: A trigger write (address 3) whose data differs from the stored trigger value reloads the counter from the load register at that edge. A trigger write of equal data leaves the counter unchanged.
- R11: While stopped, the counter ignores ticks and holds its value, except when a trigger reload occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe at the 32768 Hz count rate |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| rst_req_o | output | 1 | One-cycle reset-request pulse on overflow |

## Verification
The bench attacks the key handshake in four ways:
- A lone 0x4444 write. A design that keys on that value alone would start the counter.
- A 0xBBBB write followed by an unrelated key word and then 0x4444. A design that keeps the sequence armed would start falsely.
- A write to the load register placed between the two key words, which must not break the sequence.
- A check that the key register echoes 0x4444 while the count stays frozen.

The prescaler is checked at the exact tick where the first increment lands. A divider that is off by one, or not cleared at start, would move the count one tick early or late. The overflow case checks that the reload uses the load register and that the request lasts exactly one cycle. The trigger case checks that rewriting the stored value does not reload the counter.

// File: rtl/seqwd_pkg.sv
package seqwd_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int KEY_W  = 16;
  localparam int PSEL_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] A_LOAD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_TRIG  = 3'd3;
  localparam logic [ADDR_W-1:0] A_KEY   = 3'd4;

  localparam logic [KEY_W-1:0] K_START1 = 16'hBBBB;
  localparam logic [KEY_W-1:0] K_START2 = 16'h4444;
  localparam logic [KEY_W-1:0] K_STOP1  = 16'hAAAA;
  localparam logic [KEY_W-1:0] K_STOP2  = 16'h5555;

  typedef enum logic [1:0] {
    KS_IDLE      = 2'd0,
    KS_ARM_START = 2'd1,
    KS_ARM_STOP  = 2'd2
  } keyst_e;
endpackage

// File: rtl/seqwd_keyseq.sv
module seqwd_keyseq
  import seqwd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_wr_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             start_o,
  output logic             run_o
);
  keyst_e state_q, state_d;
  logic   stop_w;

  assign start_o = key_wr_i && (state_q == KS_ARM_START) && (key_i == K_START2);
  assign stop_w  = key_wr_i && (state_q == KS_ARM_STOP)  && (key_i == K_STOP2);

  always_comb begin
    state_d = state_q;
    if (key_wr_i) begin
      if (key_i == K_START1)     state_d = KS_ARM_START;
      else if (key_i == K_STOP1) state_d = KS_ARM_STOP;
      else                       state_d = KS_IDLE;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= KS_IDLE;
      run_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_o)     run_o <= 1'b1;
      else if (stop_w) run_o <= 1'b0;
    end
  end

  // A pending sequence survives only until the next key write
  AST_ARM_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr_i && key_i != K_START1 && key_i != K_STOP1) |=> (state_q == KS_IDLE)); // R4
endmodule

// File: rtl/seqwd_prescale.sv
module seqwd_prescale
  import seqwd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic [PSEL_W-1:0] psel_i,
  output logic              step_o
);
  localparam int DIV_W = (1 << PSEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;
  logic             wrap;

  always_comb lim = ~({DIV_W{1'b1}} << psel_i);
  assign wrap   = (div_q == lim);
  assign step_o = run_i && tick_i && (!en_i || wrap);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                     div_q <= '0;
    else if (clr_i)                  div_q <= '0;
    else if (run_i && tick_i && en_i) div_q <= wrap ? '0 : div_q + 1'b1;
  end

  AST_NO_STEP_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !step_o); // R11
endmodule

// File: rtl/seqwd_count.sv
module seqwd_count
  import seqwd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              step_i,
  input  logic              reload_i,
  input  logic [DATA_W-1:0] load_i,
  output logic [DATA_W-1:0] count_o,
  output logic              req_o
);
  logic top_w;
  assign top_w = &count_o;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      count_o <= '0;
      req_o   <= 1'b0;
    end else begin
      req_o <= 1'b0;
      if (reload_i) begin
        count_o <= load_i;
      end else if (step_i) begin
        if (top_w) begin
          count_o <= load_i;
          req_o   <= 1'b1;
        end else begin
          count_o <= count_o + 1'b1;
        end
      end
    end
  end

  AST_REQ_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(run_i)); // R9
  AST_STOPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !reload_i) |=> $stable(count_o)); // R11
endmodule

// File: rtl/seqwd_regs.sv
module seqwd_regs
  import seqwd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              run_i,
  input  logic [DATA_W-1:0] count_i,
  output logic              psc_en_o,
  output logic [PSEL_W-1:0] psel_o,
  output logic [DATA_W-1:0] load_o,
  output logic              reload_o,
  output logic              key_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PSC_BIT = 2 + PSEL_W;

  logic [DATA_W-1:0] trig_q;
  logic [KEY_W-1:0]  key_q;
  logic              ctrl_wr;

  assign ctrl_wr  = wr_en_i && (addr_i == A_CTRL) && !run_i;
  assign key_wr_o = wr_en_i && (addr_i == A_KEY);
  assign reload_o = wr_en_i && (addr_i == A_TRIG) && (wdata_i != trig_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      psc_en_o <= 1'b0;
      psel_o   <= '0;
      load_o   <= '0;
      trig_q   <= '0;
      key_q    <= '0;
    end else begin
      if (ctrl_wr) begin
        psc_en_o <= wdata_i[PSC_BIT];
        psel_o   <= wdata_i[2 +: PSEL_W];
      end
      if (wr_en_i && addr_i == A_LOAD) load_o <= wdata_i;
      if (wr_en_i && addr_i == A_TRIG) trig_q <= wdata_i;
      if (key_wr_o)                    key_q  <= wdata_i[KEY_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[PSC_BIT]      = psc_en_o;
        rdata_o[2 +: PSEL_W]  = psel_o;
      end
      A_COUNT: rdata_o = count_i;
      A_LOAD:  rdata_o = load_o;
      A_TRIG:  rdata_o = trig_q;
      A_KEY:   rdata_o[KEY_W-1:0] = key_q;
      default: rdata_o = '0;
    endcase
  end

  AST_CTRL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> ($stable(psc_en_o) && $stable(psel_o))); // R8
endmodule

// File: rtl/seqwd_top.sv
module seqwd_top
  import seqwd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o
);
  logic              run, start, step, reload, key_wr, psc_en;
  logic [PSEL_W-1:0] psel;
  logic [DATA_W-1:0] load, count;

  seqwd_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .run_i(run), .count_i(count), .psc_en_o(psc_en),
    .psel_o(psel), .load_o(load), .reload_o(reload), .key_wr_o(key_wr),
    .rdata_o(rdata_o)
  );

  seqwd_keyseq u_key (
    .clk_i(clk_i), .rst_ni(rst_ni), .key_wr_i(key_wr),
    .key_i(wdata_i[KEY_W-1:0]), .start_o(start), .run_o(run)
  );

  seqwd_prescale u_psc (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .clr_i(start),
    .tick_i(tick_i), .en_i(psc_en), .psel_i(psel), .step_o(step)
  );

  seqwd_count u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .step_i(step),
    .reload_i(reload), .load_i(load), .count_o(count), .req_o(rst_req_o)
  );

  AST_START_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run) |-> $past(wr_en_i && addr_i == A_KEY && wdata_i[KEY_W-1:0] == K_START2)); // R2
  AST_STOP_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run) |-> $past(wr_en_i && addr_i == A_KEY && wdata_i[KEY_W-1:0] == K_STOP2)); // R3
endmodule

// File: tb/seqwd_top_bench.sv
module seqwd_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  seqwd_top u_seqwd_top (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rst_req_o(rst_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic start_seq; wr(3'd4, 32'hBBBB); wr(3'd4, 32'h4444); endtask
  task automatic stop_seq;  wr(3'd4, 32'hAAAA); wr(3'd4, 32'h5555); endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd1, v); check("R1 count", v, 0);
    rd(3'd0, v); check("R1 ctrl", v, 0);
    rd(3'd4, v); check("R1 key", v, 0);
    check("R1 req", {31'd0, rst_req}, 0);
    ticks(3);
    rd(3'd1, v); check("R1 stopped after reset", v, 0);
  endtask

  task automatic t_false_start;
    logic [31:0] v;
    wr(3'd4, 32'h4444);
    rd(3'd4, v); check("R5 key echo 4444", v, 32'h4444);
    ticks(3);
    rd(3'd1, v); check("R4 lone 4444 no start", v, 0);
    wr(3'd4, 32'hBBBB); wr(3'd4, 32'h1234); wr(3'd4, 32'h4444);
    ticks(2);
    rd(3'd1, v); check("R4 broken sequence no start", v, 0);
    wr(3'd4, 32'hFFFF_5A5A);
    rd(3'd4, v); check("R5 key low 16 bits", v, 32'h5A5A);
  endtask

  task automatic t_start_run;
    logic [31:0] v;
    wr(3'd2, 32'd100);
    wr(3'd3, 32'd1);
    rd(3'd1, v); check("R10 trigger reload stopped", v, 32'd100);
    wr(3'd4, 32'hBBBB); wr(3'd2, 32'd7); wr(3'd4, 32'h4444);
    ticks(5);
    rd(3'd1, v); check("R2 R6 counts 1 per tick", v, 32'd105);
    rd(3'd4, v); check("R5 key reads 4444 running", v, 32'h4444);
    wr(3'd0, 32'h3C);
    rd(3'd0, v); check("R8 ctrl write ignored running", v, 0);
    wr(3'd3, 32'd1);
    rd(3'd1, v); check("R10 same trigger no reload", v, 32'd105);
    wr(3'd3, 32'd2);
    rd(3'd1, v); check("R10 new trigger reloads", v, 32'd7);
    stop_seq();
    ticks(4);
    rd(3'd1, v); check("R3 R11 stopped holds", v, 32'd7);
  endtask

  task automatic t_prescale;
    logic [31:0] v;
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); check("R8 ctrl stored bits", v, 32'h3C);
    wr(3'd0, 32'h28);           // enable, p=2
    wr(3'd2, 32'd0); wr(3'd3, 32'd3);
    start_seq();
    ticks(3);
    rd(3'd1, v); check("R7 no step before 4th tick", v, 0);
    ticks(1);
    rd(3'd1, v); check("R7 step at 4th tick", v, 1);
    ticks(8);
    rd(3'd1, v); check("R7 rate 1 per 4", v, 3);
    stop_seq();
  endtask

  task automatic t_overflow;
    logic [31:0] v;
    wr(3'd0, 32'h0);
    wr(3'd2, 32'hFFFF_FFFE); wr(3'd3, 32'd4);
    start_seq();
    ticks(1);
    rd(3'd1, v); check("R9 at top", v, 32'hFFFF_FFFF);
    check("R9 no req before wrap", {31'd0, rst_req}, 0);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check("R9 req high", {31'd0, rst_req}, 1);
    rd(3'd1, v); check("R9 reload on wrap", v, 32'hFFFF_FFFE);
    @(negedge clk);
    check("R9 req one cycle", {31'd0, rst_req}, 0);
    stop_seq();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_false_start();
    t_start_run();
    t_prescale();
    t_overflow();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          bad++; total++;
          $display("FAIL watchdog timeout actual=hung expected=done");
        end
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule